// File: doc/BRIEF.md
# Configuration Space Access Window

This block gives a processor indirect access to device configuration registers through two register windows. The first is a 32-bit pointer register. It selects an enable flag, a bus number, a combined device/function number and a register offset. The second is a four-byte data window. An access to the data window is turned into a configuration read or write on a downstream request/response interface. Any access that cannot be completed is dropped on write and returns all-ones on read.

Each data-window access runs as a short transaction. The block first sends a probe request so that the downstream side reports whether the target exists. Only when the target is visible does the block send the real read or write. The processor port holds `cpu_ready` low until the transaction finishes. Before any request goes out, the block merges the window byte offset into the stored offset. It also enforces the configuration-space limit and shortens the transfer so that it never crosses that limit.

Top module: `cfg_window_bridge`

## Requirements
- R1: A write to the pointer window (`cpu_sel`=0) updates the pointer only when `cpu_off` is 0 and `cpu_len` is 4. Any other pointer write leaves the pointer unchanged.
- R2: A read of the pointer window returns the full 32-bit pointer, whatever `cpu_off` and `cpu_len` are.
- R3: Pointer bit 31 is the enable. While it is 0, a data-window (`cpu_sel`=1) write sends no downstream request, and a data-window read returns 32'hFFFF_FFFF without any request.
- R4: On the downstream interface, the bus is pointer bits 23:16 and the device/function is pointer bits 15:8. The register offset is pointer bits 7:0 ORed with `cpu_off`, taken modulo `CFG_SPACE` (256).
- R5: If the merged offset is at or above `CFG_LIMIT`, no downstream request is issued. A write is dropped and a read returns all-ones.
- R6: The downstream length is the smaller of `cpu_len` and (`CFG_LIMIT` − offset). Read data is right-aligned, with every byte above that length forced to zero.
- R7: If the probe reports the target absent (`dn_rsp_present`=0), no access request follows. A write is dropped and a read returns all-ones.
- R8: A target reported hot-added (`dn_rsp_hotadd`=1) whose function 0 is reported absent (`dn_rsp_fn0`=0) is treated as absent, as in R7.
- R9: Downstream requests are one at a time. A probe (`dn_req_op`=0) always comes first and an access (read=1, write=2) follows it. The request fields stay stable while `dn_req_valid` is high and no response has arrived.
- R10: Reset clears the pointer to zero. `cpu_ready` is a one-cycle pulse marking completion, with `cpu_rdata` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor access request, held until `cpu_ready` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 1 | 0 = pointer window, 1 = data window |
| cpu_off | input | 2 | Byte offset within the window |
| cpu_len | input | 3 | Access length in bytes (1, 2 or 4) |
| cpu_wdata | input | 32 | Right-aligned write data |
| cpu_ready | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Right-aligned read data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_op | output | 2 | 0 probe, 1 read, 2 write |
| dn_req_bus | output | 8 | Target bus number |
| dn_req_devfn | output | 8 | Target device/function |
| dn_req_off | output | 8 | Register offset |
| dn_req_len | output | 3 | Clamped byte length |
| dn_req_wdata | output | 32 | Right-aligned write data, masked to length |
| dn_rsp_valid | input | 1 | Response to the current request |
| dn_rsp_present | input | 1 | Probe: target exists |
| dn_rsp_hotadd | input | 1 | Probe: target was hot-added |
| dn_rsp_fn0 | input | 1 | Probe: function 0 of the same device exists |
| dn_rsp_rdata | input | 32 | Access read data, right-aligned |

## Verification
The window byte-offset merge and the limit clamp act on the same access. When the stored offset sits just below `CFG_LIMIT` and `cpu_off` pushes it up, the merged offset alone decides how many bytes remain. The bench provokes this with a bench instance limit of 192: it points at offset 0xBC and reads at window offset 3 with length 2. It then expects a one-byte downstream length and a result masked to one byte. The reference model in the bench also predicts every downstream request, including whether one may appear at all. The bench compares each observed request against that prediction, and the device model fills the unused upper read bytes with filler so that missing masking shows up.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int PTR_W     = 32;
  localparam int EN_BIT    = 31;
  localparam int FIELD_W   = 8;
  localparam int BUS_LSB   = 16;
  localparam int DEVFN_LSB = 8;
  localparam int DATA_W    = 32;
  localparam int LEN_W     = 3;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } dn_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PROBE  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } ctl_state_e;

  // Right-aligned byte mask covering n bytes (n = 1..4)
  function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] n);
    logic [DATA_W-1:0] m;
    case (n)
      3'd1:    m = 32'h0000_00FF;
      3'd2:    m = 32'h0000_FFFF;
      3'd3:    m = 32'h00FF_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/cfgwin_ptr_reg.sv
module cfgwin_ptr_reg #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_data,
  output logic [PTR_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (rst)        ptr_q <= '0;
    else if (wr_en) ptr_q <= wr_data;
  end
endmodule

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int CFG_SPACE = 256,
  parameter int CFG_LIMIT = 256,
  localparam int OFF_W    = $clog2(CFG_SPACE),
  localparam int FLD_TOP  = BUS_LSB + FIELD_W
) (
  input  logic [FLD_TOP-1:0] ptr_fields,
  input  logic [1:0]         win_off,
  input  logic [LEN_W-1:0]   req_len,
  output logic [FIELD_W-1:0] bus,
  output logic [FIELD_W-1:0] devfn,
  output logic [OFF_W-1:0]   reg_off,
  output logic               in_range,
  output logic [LEN_W-1:0]   xfer_len
);
  localparam logic [OFF_W:0] LIM = (OFF_W+1)'(CFG_LIMIT);

  logic [OFF_W:0] remaining;

  always_comb begin
    bus       = ptr_fields[BUS_LSB +: FIELD_W];
    devfn     = ptr_fields[DEVFN_LSB +: FIELD_W];
    reg_off   = ptr_fields[OFF_W-1:0] | OFF_W'(win_off);
    in_range  = {1'b0, reg_off} < LIM;
    remaining = LIM - {1'b0, reg_off};
    if ((OFF_W+1)'(req_len) > remaining) xfer_len = remaining[LEN_W-1:0];
    else                                 xfer_len = req_len;
  end
endmodule

// File: rtl/cfgwin_ctrl.sv
module cfgwin_ctrl
  import cfgwin_pkg::*;
#(
  parameter int CFG_SPACE = 256,
  parameter int CFG_LIMIT = 256,
  localparam int OFF_W    = $clog2(CFG_SPACE)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_valid,
  input  logic               cpu_write,
  input  logic               cpu_sel,
  input  logic [1:0]         cpu_off,
  input  logic [LEN_W-1:0]   cpu_len,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic [DATA_W-1:0]  cpu_rdata,
  input  logic [PTR_W-1:0]   ptr_q,
  output logic               ptr_wr_en,
  input  logic [FIELD_W-1:0] dec_bus,
  input  logic [FIELD_W-1:0] dec_devfn,
  input  logic [OFF_W-1:0]   dec_off,
  input  logic               dec_in_range,
  input  logic [LEN_W-1:0]   dec_len,
  output logic               dn_req_valid,
  output logic [1:0]         dn_req_op,
  output logic [FIELD_W-1:0] dn_req_bus,
  output logic [FIELD_W-1:0] dn_req_devfn,
  output logic [OFF_W-1:0]   dn_req_off,
  output logic [LEN_W-1:0]   dn_req_len,
  output logic [DATA_W-1:0]  dn_req_wdata,
  input  logic               dn_rsp_valid,
  input  logic               dn_rsp_present,
  input  logic               dn_rsp_hotadd,
  input  logic               dn_rsp_fn0,
  input  logic [DATA_W-1:0]  dn_rsp_rdata
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;
  localparam logic [OFF_W:0]    LIM      = (OFF_W+1)'(CFG_LIMIT);

  ctl_state_e         state_q;
  logic               wr_q;
  logic [FIELD_W-1:0] bus_q, devfn_q;
  logic [OFF_W-1:0]   off_q;
  logic [LEN_W-1:0]   len_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               accept, visible;

  assign accept    = (state_q == ST_IDLE) && cpu_valid;
  assign ptr_wr_en = accept && !cpu_sel && cpu_write &&
                     (cpu_off == 2'd0) && (cpu_len == 3'd4);
  assign visible   = dn_rsp_present && (!dn_rsp_hotadd || dn_rsp_fn0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      bus_q   <= '0;
      devfn_q <= '0;
      off_q   <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_valid) begin
          wr_q <= cpu_write;
          if (!cpu_sel) begin
            rdata_q <= cpu_write ? '0 : ptr_q;
            state_q <= ST_DONE;
          end else if (!ptr_q[EN_BIT] || !dec_in_range) begin
            rdata_q <= cpu_write ? '0 : ALL_ONES;
            state_q <= ST_DONE;
          end else begin
            bus_q   <= dec_bus;
            devfn_q <= dec_devfn;
            off_q   <= dec_off;
            len_q   <= dec_len;
            wdata_q <= cpu_wdata & len_mask(dec_len);
            state_q <= ST_PROBE;
          end
        end
        ST_PROBE: if (dn_rsp_valid) begin
          if (visible) begin
            state_q <= ST_ACCESS;
          end else begin
            rdata_q <= wr_q ? '0 : ALL_ONES;
            state_q <= ST_DONE;
          end
        end
        ST_ACCESS: if (dn_rsp_valid) begin
          rdata_q <= wr_q ? '0 : (dn_rsp_rdata & len_mask(len_q));
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready    = (state_q == ST_DONE);
  assign cpu_rdata    = rdata_q;
  assign dn_req_valid = (state_q == ST_PROBE) || (state_q == ST_ACCESS);
  assign dn_req_op    = (state_q == ST_PROBE) ? OP_PROBE : (wr_q ? OP_WRITE : OP_READ);
  assign dn_req_bus   = bus_q;
  assign dn_req_devfn = devfn_q;
  assign dn_req_off   = off_q;
  assign dn_req_len   = len_q;
  assign dn_req_wdata = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && !dn_rsp_valid) |=> (dn_req_valid && $stable(dn_req_op) &&
      $stable(dn_req_bus) && $stable(dn_req_devfn) && $stable(dn_req_off) &&
      $stable(dn_req_len))); // R9
  AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_req_valid) |-> (dn_req_op == OP_PROBE)); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R10
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> (dn_req_len >= 3'd1 && dn_req_len <= 3'd4 &&
      ({1'b0, dn_req_off} + (OFF_W+1)'(dn_req_len)) <= LIM)); // R6
endmodule

// File: rtl/cfg_window_bridge.sv
module cfg_window_bridge
  import cfgwin_pkg::*;
#(
  parameter int CFG_SPACE = 256,
  parameter int CFG_LIMIT = 256,
  localparam int OFF_W    = $clog2(CFG_SPACE),
  localparam int FLD_TOP  = BUS_LSB + FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_valid,
  input  logic               cpu_write,
  input  logic               cpu_sel,
  input  logic [1:0]         cpu_off,
  input  logic [LEN_W-1:0]   cpu_len,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               dn_req_valid,
  output logic [1:0]         dn_req_op,
  output logic [FIELD_W-1:0] dn_req_bus,
  output logic [FIELD_W-1:0] dn_req_devfn,
  output logic [OFF_W-1:0]   dn_req_off,
  output logic [LEN_W-1:0]   dn_req_len,
  output logic [DATA_W-1:0]  dn_req_wdata,
  input  logic               dn_rsp_valid,
  input  logic               dn_rsp_present,
  input  logic               dn_rsp_hotadd,
  input  logic               dn_rsp_fn0,
  input  logic [DATA_W-1:0]  dn_rsp_rdata
);
  logic [PTR_W-1:0]   ptr_q;
  logic               ptr_wr_en;
  logic [FIELD_W-1:0] dec_bus, dec_devfn;
  logic [OFF_W-1:0]   dec_off;
  logic               dec_in_range;
  logic [LEN_W-1:0]   dec_len;

  cfgwin_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .wr_en(ptr_wr_en), .wr_data(cpu_wdata), .ptr_q(ptr_q)
  );

  cfgwin_decode #(.CFG_SPACE(CFG_SPACE), .CFG_LIMIT(CFG_LIMIT)) u_dec (
    .ptr_fields(ptr_q[FLD_TOP-1:0]), .win_off(cpu_off), .req_len(cpu_len),
    .bus(dec_bus), .devfn(dec_devfn), .reg_off(dec_off),
    .in_range(dec_in_range), .xfer_len(dec_len)
  );

  cfgwin_ctrl #(.CFG_SPACE(CFG_SPACE), .CFG_LIMIT(CFG_LIMIT)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_sel(cpu_sel),
    .cpu_off(cpu_off), .cpu_len(cpu_len), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .ptr_q(ptr_q), .ptr_wr_en(ptr_wr_en),
    .dec_bus(dec_bus), .dec_devfn(dec_devfn), .dec_off(dec_off),
    .dec_in_range(dec_in_range), .dec_len(dec_len),
    .dn_req_valid(dn_req_valid), .dn_req_op(dn_req_op), .dn_req_bus(dn_req_bus),
    .dn_req_devfn(dn_req_devfn), .dn_req_off(dn_req_off), .dn_req_len(dn_req_len),
    .dn_req_wdata(dn_req_wdata), .dn_rsp_valid(dn_rsp_valid),
    .dn_rsp_present(dn_rsp_present), .dn_rsp_hotadd(dn_rsp_hotadd),
    .dn_rsp_fn0(dn_rsp_fn0), .dn_rsp_rdata(dn_rsp_rdata)
  );

  AST_EN_GATE: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> ptr_q[EN_BIT]); // R3
  AST_PTR_GUARD: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_write && !cpu_sel && (cpu_off != 2'd0 || cpu_len != 3'd4))
      |=> $stable(ptr_q)); // R1
endmodule

// File: tb/cfg_window_bridge_bench.sv
module cfg_window_bridge_bench;
  localparam int LIMIT = 192;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0, cpu_sel = 1'b0;
  logic [1:0]  cpu_off = '0;
  logic [2:0]  cpu_len = 3'd4;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        dn_req_valid;
  logic [1:0]  dn_req_op;
  logic [7:0]  dn_req_bus, dn_req_devfn, dn_req_off;
  logic [2:0]  dn_req_len;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0, dn_rsp_present = 1'b0;
  logic        dn_rsp_hotadd = 1'b0, dn_rsp_fn0 = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  int tests = 0, fails = 0, cycles = 0, commits = 0;
  logic [31:0] model_ptr = '0;
  logic [7:0]  mem [int];
  bit          exp_allowed, exp_usable, exp_wr, probed;
  logic [7:0]  exp_bus, exp_devfn, exp_off;
  logic [2:0]  exp_len;
  string       gate_tag;

  always #4 clk = ~clk;

  cfg_window_bridge #(.CFG_LIMIT(LIMIT)) u_cfg_window_bridge (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit dev_exists(input logic [7:0] b, input logic [7:0] df);
    return (b == 8'd0 && (df == 8'h08 || df == 8'h09 || df == 8'h12)) ||
           (b == 8'd1 && df == 8'h00);
  endfunction
  function automatic bit dev_hot(input logic [7:0] b, input logic [7:0] df);
    return b == 8'd0 && (df == 8'h09 || df == 8'h12);
  endfunction
  function automatic int key(input logic [7:0] b, input logic [7:0] df, input int o);
    return (int'(b) << 16) | (int'(df) << 8) | (o & 255);
  endfunction
  function automatic logic [7:0] rd_byte(input logic [7:0] b, input logic [7:0] df, input int o);
    int k = key(b, df, o);
    return mem.exists(k) ? mem[k] : (8'(o) ^ df ^ 8'h5A);
  endfunction

  // Downstream device model
  initial begin
    int wcnt = 0, lat = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        dn_rsp_valid = 1'b0; wcnt = 0;
      end else if (dn_rsp_valid) begin
        dn_rsp_valid = 1'b0;
      end else if (dn_req_valid) begin
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0; lat = (lat + 1) % 3;
          chk({gate_tag, " request permitted"}, 32'd1, {31'd0, exp_allowed});
          chk("R4 bus", {24'd0, dn_req_bus}, {24'd0, exp_bus});
          chk("R4 devfn", {24'd0, dn_req_devfn}, {24'd0, exp_devfn});
          if (dn_req_op == 2'd0) begin
            probed = 1'b1;
            dn_rsp_present = dev_exists(dn_req_bus, dn_req_devfn);
            dn_rsp_hotadd  = dev_hot(dn_req_bus, dn_req_devfn);
            dn_rsp_fn0     = dev_exists(dn_req_bus, {dn_req_devfn[7:3], 3'b000});
            dn_rsp_rdata   = 32'hDEAD_BEEF;
          end else begin
            chk("R9 probe precedes access", {31'd0, probed}, 32'd1);
            chk("R7/R8 access only to visible target", {31'd0, exp_usable}, 32'd1);
            chk("R9 access op", {30'd0, dn_req_op}, exp_wr ? 32'd2 : 32'd1);
            chk("R4 offset", {24'd0, dn_req_off}, {24'd0, exp_off});
            chk("R6 length", {29'd0, dn_req_len}, {29'd0, exp_len});
            if (dn_req_op == 2'd2) begin
              commits++;
              for (int i = 0; i < int'(dn_req_len); i++)
                mem[key(dn_req_bus, dn_req_devfn, int'(dn_req_off) + i)] = dn_req_wdata[8*i +: 8];
            end else begin
              dn_rsp_rdata = 32'hA5A5_A5A5;
              for (int i = 0; i < int'(dn_req_len); i++)
                dn_rsp_rdata[8*i +: 8] = rd_byte(dn_req_bus, dn_req_devfn, int'(dn_req_off) + i);
            end
          end
          dn_rsp_valid = 1'b1;
        end
      end
    end
  end

  // Reference model plus driver for one processor access
  task automatic xfer(input string tag, input bit wr, input bit sel, input logic [1:0] off,
                      input logic [2:0] len, input logic [31:0] wd);
    logic [31:0] exp_rd = 32'hFFFF_FFFF;
    int o, rem, n = 0, c0 = commits;
    bit commit_exp = 1'b0;
    exp_allowed = 1'b0; exp_usable = 1'b0; exp_wr = wr; probed = 1'b0;
    gate_tag = "R3";
    if (!sel) begin
      exp_rd = model_ptr;
    end else if (model_ptr[31]) begin
      exp_bus = model_ptr[23:16]; exp_devfn = model_ptr[15:8];
      o = int'(model_ptr[7:0] | {6'd0, off});
      exp_off = 8'(o);
      gate_tag = "R5";
      if (o < LIMIT) begin
        exp_allowed = 1'b1;
        rem = LIMIT - o;
        exp_len = (int'(len) < rem) ? len : 3'(rem);
        exp_usable = dev_exists(exp_bus, exp_devfn) &&
          (!dev_hot(exp_bus, exp_devfn) || dev_exists(exp_bus, {exp_devfn[7:3], 3'b000}));
        if (exp_usable) begin
          commit_exp = wr;
          exp_rd = '0;
          for (int i = 0; i < int'(exp_len); i++) exp_rd[8*i +: 8] = rd_byte(exp_bus, exp_devfn, o + i);
        end
      end
    end
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = wr; cpu_sel = sel; cpu_off = off; cpu_len = len; cpu_wdata = wd;
    do begin @(negedge clk); n++; end while (!cpu_ready && n < 2000);
    chk({tag, " completion seen"}, {31'd0, cpu_ready}, 32'd1);
    if (!wr) chk(tag, cpu_rdata, exp_rd);
    cpu_valid = 1'b0;
    if (sel && wr) chk({tag, " write committed"}, commits - c0, {31'd0, commit_exp});
    if (!sel && wr && off == 2'd0 && len == 3'd4) model_ptr = wd;
    @(negedge clk);
    chk("R10 ready is a single pulse", {31'd0, cpu_ready}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R10 reset ready low", {31'd0, cpu_ready}, 32'd0);
    chk("R9 reset no request", {31'd0, dn_req_valid}, 32'd0);
    xfer("R10 pointer cleared by reset", 0, 0, 2'd0, 3'd4, 0);
    xfer("R3 read while disabled", 0, 1, 2'd0, 3'd4, 0);
    xfer("R3 write while disabled", 1, 1, 2'd0, 3'd4, 32'h1234_5678);
    xfer("R1 pointer write at offset 2", 1, 0, 2'd2, 3'd4, 32'h8000_0810);
    xfer("R1 pointer write of length 2", 1, 0, 2'd0, 3'd2, 32'h8000_0810);
    xfer("R1 ignored writes leave pointer", 0, 0, 2'd0, 3'd4, 0);
    xfer("R1 pointer write accepted", 1, 0, 2'd0, 3'd4, 32'h8000_0810);
    xfer("R2 pointer read at offset 3 length 1", 0, 0, 2'd3, 3'd1, 0);
    xfer("R4 data write", 1, 1, 2'd0, 3'd4, 32'h1122_3344);
    xfer("R4 data read back", 0, 1, 2'd0, 3'd4, 0);
    xfer("R6 byte read at window offset 1", 0, 1, 2'd1, 3'd1, 0);
    xfer("R6 half read at window offset 2", 0, 1, 2'd2, 3'd2, 0);
    xfer("R1 pointer with low bits", 1, 0, 2'd0, 3'd4, 32'h8000_0813);
    xfer("R4 offset merge by OR", 0, 1, 2'd1, 3'd1, 0);
    xfer("R1 point at absent device", 1, 0, 2'd0, 3'd4, 32'h8000_0A00);
    xfer("R7 write to absent device", 1, 1, 2'd0, 3'd4, 32'hFFFF_0000);
    xfer("R7 read from absent device", 0, 1, 2'd0, 3'd4, 0);
    xfer("R1 point at hidden function", 1, 0, 2'd0, 3'd4, 32'h8000_1204);
    xfer("R8 write to hidden function", 1, 1, 2'd0, 3'd4, 32'h0BAD_0BAD);
    xfer("R8 read from hidden function", 0, 1, 2'd0, 3'd4, 0);
    xfer("R1 point at hot-added function", 1, 0, 2'd0, 3'd4, 32'h8000_0904);
    xfer("R8 write visible hot-added", 1, 1, 2'd0, 3'd4, 32'hA1B2_C3D4);
    xfer("R8 read visible hot-added", 0, 1, 2'd0, 3'd4, 0);
    xfer("R1 point near limit", 1, 0, 2'd0, 3'd4, 32'h8000_08BE);
    xfer("R6 clamped read", 0, 1, 2'd0, 3'd4, 0);
    xfer("R6 clamped write", 1, 1, 2'd0, 3'd4, 32'hCAFE_F00D);
    xfer("R6 clamped read back", 0, 1, 2'd0, 3'd4, 0);
    xfer("R1 point below limit", 1, 0, 2'd0, 3'd4, 32'h8000_08BC);
    xfer("R6 merge and clamp together", 0, 1, 2'd3, 3'd2, 0);
    xfer("R1 point past limit", 1, 0, 2'd0, 3'd4, 32'h8000_08C0);
    xfer("R5 read past limit", 0, 1, 2'd0, 3'd4, 0);
    xfer("R5 write past limit", 1, 1, 2'd3, 3'd1, 32'h0000_0077);
    xfer("R1 point at bus 1", 1, 0, 2'd0, 3'd4, 32'h8001_0020);
    xfer("R4 bus 1 write", 1, 1, 2'd2, 3'd2, 32'h0000_BEEF);
    xfer("R4 bus 1 read", 0, 1, 2'd0, 3'd4, 0);
    xfer("R1 disable with present target", 1, 0, 2'd0, 3'd4, 32'h0000_0810);
    xfer("R3 read disabled present target", 0, 1, 2'd0, 3'd4, 0);
    xfer("R3 write disabled present target", 1, 1, 2'd0, 3'd4, 32'h5555_5555);
    xfer("R1 re-enable", 1, 0, 2'd0, 3'd4, 32'h8000_0810);
    xfer("R3 disabled write left data intact", 0, 1, 2'd0, 3'd4, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule